// File: doc/BRIEF.md
# Single-to-Double Load Widening Unit

This unit takes a 32-bit IEEE-754 single-precision word, as read from memory by a floating-point load, and produces the 64-bit double-precision register image of the same value. Normal numbers, signed zeros, infinities and NaNs are widened in the same cycle that the request is accepted. The unit copies and replicates bits to do this and performs no arithmetic on them.

Subnormal singles cannot be expressed as subnormal doubles, so the unit normalizes them. It shifts a 53-bit working significand left by one position per clock and lowers a signed working exponent by one per shift. When the leading significand bit is 1, it rebiases the exponent and packs the double. The conversion is exact in every case, so there is no rounding and no flag output. A request is a one-cycle `start_i` pulse together with `word_i`. Completion is a one-cycle `done_o` pulse, and `result_o` holds the value until the next completion.

Top module: `fp_load_widen`

## Requirements
In this section, bit *k* is counted from the least significant bit (bit 0). Input fields are: sign = `word_i[31]`, exponent field E = `word_i[30:23]`, fraction F = `word_i[22:0]`.
- R1: While reset is asserted, and in the first cycle after reset, `done_o` is 0 and `result_o` is all zeros.
- R2: When the unit is idle and a start arrives with E in the range 1..254, `done_o` is 1 on the rising edge that samples the start. On that edge, `result_o[63:62]` = `word_i[31:30]`, each of `result_o[61:59]` = NOT `word_i[30]`, and `result_o[58:0]` = {`word_i[29:0]`, 29 zero bits}.
- R3: When the unit is idle and a start arrives with E = 255, or with `word_i[30:0]` = 0 (either signed zero), the result is formed as in R2 with one change: each of `result_o[61:59]` copies `word_i[30]` without inversion. The latency is the same as in R2.
- R4: For a subnormal input (E = 0, F ≠ 0), let L be the number of leading zeros of the 23-bit F (0..22). The result is as follows:
  - `result_o[63]` = sign.
  - `result_o[62:52]` = 896 − L, which always lies in 874..896.
  - `result_o[51:0]` = the 52 bits of {F, 29 zeros} shifted left by L+1, with the bits shifted out at the top dropped.
- R5: A subnormal request asserts `done_o` on the (L+3)-th rising edge, counting the edge that samples the start as the first. `done_o` stays 0 on all the edges before it.
- R6: While a subnormal is being normalized, `start_i` is ignored. The result and latency of the conversion in progress are unchanged, and no extra `done_o` pulse follows.
- R7: Each accepted request yields exactly one single-cycle `done_o` pulse. Starts on consecutive cycles while idle are each accepted and complete on consecutive cycles.
- R8: `result_o` keeps its value on every cycle in which `done_o` is 0, whatever `word_i` does.
- R9: A reset asserted during normalization abandons that conversion. After reset, the next request converts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; accepted only while idle |
| word_i | input | 32 | Single-precision word, sampled with the accepted start |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Double-precision image, held until the next completion |

## Verification
The direct path is tried with several words:
- 1.0, 5.0 and −2.0 show that the inverted exponent bits are replicated correctly.
- The largest and smallest normals exercise the top and bottom of the exponent field.
- Positive and negative zero, infinity, a quiet NaN and an all-ones NaN separate the non-inverting special path from the normal one.

The subnormal path is tried with several words:
- Fractions with the top bit set (one and several ones) give the shortest normalization.
- A fraction of 1 gives the longest normalization, and a fraction of 3 gives the next longest. Together they confirm that the exponent falls by exactly one per shift and that the trailing fraction bits land in the right place.

Latency is measured for every vector, which separates the direct path from the iterative one. Further directed sequences cover the following:
- a start during normalization
- back-to-back starts while idle
- holding the result while idle
- reset during normalization

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    localparam int SP_W     = 32;
    localparam int SP_EW    = 8;
    localparam int SP_FW    = SP_W - SP_EW - 1;
    localparam int DP_W     = 64;
    localparam int DP_EW    = 11;
    localparam int DP_FW    = DP_W - DP_EW - 1;
    localparam int SIG_W    = DP_FW + 1;
    localparam int EXP_W    = DP_EW + 1;
    localparam int PAD_W    = DP_FW - SP_FW;
    localparam int REPL_W   = DP_EW - SP_EW;
    localparam int SP_BIAS  = (1 << (SP_EW - 1)) - 1;
    localparam int DP_BIAS  = (1 << (DP_EW - 1)) - 1;
    localparam int SP_EMIN  = 1 - SP_BIAS;

    typedef enum logic [1:0] {
        CLS_NORMAL  = 2'd0,
        CLS_SPECIAL = 2'd1,
        CLS_SUBNORM = 2'd2
    } word_class_e;

    typedef struct packed {
        logic                     busy;
        logic                     sign;
        logic [SIG_W-1:0]         sig;
        logic signed [EXP_W-1:0]  expo;
        logic                     done;
        logic [DP_W-1:0]          result;
    } widen_state_t;
endpackage

// File: rtl/fpw_classify.sv
module fpw_classify
    import fpw_pkg::*;
(
    input  logic [SP_EW-1:0] efield_i,
    input  logic [SP_FW-1:0] ffield_i,
    output word_class_e      cls_o
);
    logic e_zero, e_ones, f_zero;

    always_comb begin
        e_zero = (efield_i == '0);
        e_ones = (efield_i == '1);
        f_zero = (ffield_i == '0);
        if (e_ones || (e_zero && f_zero)) begin
            cls_o = CLS_SPECIAL;
        end else if (e_zero) begin
            cls_o = CLS_SUBNORM;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/fpw_direct_widen.sv
module fpw_direct_widen
    import fpw_pkg::*;
(
    input  logic [SP_W-1:0] word_i,
    input  logic            invert_i,
    output logic [DP_W-1:0] wide_o
);
    logic emsb;

    always_comb begin
        emsb   = word_i[SP_W-2];
        // sign and exponent MSB pass through, then the replicated field
        wide_o = {word_i[SP_W-1:SP_W-2],
                  {REPL_W{emsb ^ invert_i}},
                  word_i[SP_W-3:0],
                  {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/fpw_norm_step.sv
module fpw_norm_step
    import fpw_pkg::*;
(
    input  logic [SIG_W-1:0]        sig_i,
    input  logic signed [EXP_W-1:0] expo_i,
    output logic                    lead_o,
    output logic [SIG_W-1:0]        sig_o,
    output logic signed [EXP_W-1:0] expo_o
);
    always_comb begin
        lead_o = sig_i[SIG_W-1];
        sig_o  = {sig_i[SIG_W-2:0], 1'b0};
        expo_o = expo_i - EXP_W'(1);
    end
endmodule

// File: rtl/fpw_pack.sv
module fpw_pack
    import fpw_pkg::*;
(
    input  logic             sign_i,
    input  logic [DP_EW-1:0] expo_lo_i,
    input  logic [DP_FW-1:0] mant_i,
    output logic [DP_W-1:0]  dbl_o
);
    logic [DP_EW-1:0] biased;

    always_comb begin
        // low bits of (expo + bias) do not depend on the dropped sign bit
        biased = expo_lo_i + DP_EW'(DP_BIAS);
        dbl_o  = {sign_i, biased, mant_i};
    end
endmodule

// File: rtl/fp_load_widen.sv
module fp_load_widen
    import fpw_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [SP_W-1:0] word_i,
    output logic            done_o,
    output logic [DP_W-1:0] result_o
);
    widen_state_t st_d, st_q;

    word_class_e             cls;
    logic [DP_W-1:0]         direct_res;
    logic                    step_lead;
    logic [SIG_W-1:0]        step_sig;
    logic signed [EXP_W-1:0] step_expo;
    logic [DP_W-1:0]         packed_res;
    logic                    busy;

    fpw_classify u_cls (
        .efield_i (word_i[SP_W-2:SP_FW]),
        .ffield_i (word_i[SP_FW-1:0]),
        .cls_o    (cls)
    );

    fpw_direct_widen u_direct (
        .word_i   (word_i),
        .invert_i (cls == CLS_NORMAL),
        .wide_o   (direct_res)
    );

    fpw_norm_step u_step (
        .sig_i  (st_q.sig),
        .expo_i (st_q.expo),
        .lead_o (step_lead),
        .sig_o  (step_sig),
        .expo_o (step_expo)
    );

    fpw_pack u_pack (
        .sign_i    (st_q.sign),
        .expo_lo_i (st_q.expo[DP_EW-1:0]),
        .mant_i    (st_q.sig[DP_FW-1:0]),
        .dbl_o     (packed_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                if (cls == CLS_SUBNORM) begin
                    st_d.busy = 1'b1;
                    st_d.sign = word_i[SP_W-1];
                    st_d.sig  = {1'b0, word_i[SP_FW-1:0], {PAD_W{1'b0}}};
                    st_d.expo = EXP_W'(SP_EMIN);
                end else begin
                    st_d.result = direct_res;
                    st_d.done   = 1'b1;
                end
            end
        end else if (step_lead) begin
            st_d.result = packed_res;
            st_d.done   = 1'b1;
            st_d.busy   = 1'b0;
        end else begin
            st_d.sig  = step_sig;
            st_d.expo = step_expo;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done_o   = st_q.done;
    assign result_o = st_q.result;
endmodule

// File: rtl/fpw_checker.sv
module fpw_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic [31:0] word_i,
    input logic        done_o,
    input logic [63:0] result_o,
    input logic        busy_i
);
    logic is_norm, is_spec, is_sub;
    assign is_norm = (word_i[30:23] != 8'h00) && (word_i[30:23] != 8'hFF);
    assign is_spec = (word_i[30:23] == 8'hFF) || (word_i[30:0] == 31'd0);
    assign is_sub  = (word_i[30:23] == 8'h00) && (word_i[22:0] != 23'd0);

    p_normal_widen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && is_norm) |=>
        (done_o && result_o[63:59] == {$past(word_i[31:30]), {3{~$past(word_i[30])}}}
                && result_o[58:0] == {$past(word_i[29:0]), 29'd0}));

    p_special_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && is_spec) |=>
        (done_o && result_o[61:59] == {3{$past(word_i[30])}}
                && result_o[63:62] == $past(word_i[31:30])));

    p_subnorm_exp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(busy_i)) |->
        (result_o[62:52] >= 11'd874 && result_o[62:52] <= 11'd896));

    p_subnorm_defer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i && is_sub) |=> (!done_o && busy_i));

    p_no_done_while_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> !done_o);

    p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));
endmodule

bind fp_load_widen fpw_checker u_fpw_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .word_i   (word_i),
    .done_o   (done_o),
    .result_o (result_o),
    .busy_i   (busy)
);

// File: tb/fp_load_widen_bench.sv
module fp_load_widen_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        done_o;
    logic [63:0] result_o;

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;
    bit finished = 1'b0;

    always #10 clk_i = ~clk_i;

    fp_load_widen u_fp_load_widen (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .word_i(word_i), .done_o(done_o), .result_o(result_o)
    );

    // {word, expected double, expected latency in edges}
    localparam int NV = 15;
    localparam logic [103:0] VEC [NV] = '{
        {32'h3F800000, 64'h3FF0000000000000, 8'd1},
        {32'h40A00000, 64'h4014000000000000, 8'd1},
        {32'hC0000000, 64'hC000000000000000, 8'd1},
        {32'h7F7FFFFF, 64'h47EFFFFFE0000000, 8'd1},
        {32'h00800000, 64'h3810000000000000, 8'd1},
        {32'h00000000, 64'h0000000000000000, 8'd1},
        {32'h80000000, 64'h8000000000000000, 8'd1},
        {32'h7F800000, 64'h7FF0000000000000, 8'd1},
        {32'h7FC00000, 64'h7FF8000000000000, 8'd1},
        {32'hFFFFFFFF, 64'hFFFFFFFFE0000000, 8'd1},
        {32'h00000001, 64'h36A0000000000000, 8'd25},
        {32'h00000003, 64'h36B8000000000000, 8'd24},
        {32'h00400000, 64'h3800000000000000, 8'd3},
        {32'h00600000, 64'h3808000000000000, 8'd3},
        {32'h807FFFFF, 64'hB80FFFFFC0000000, 8'd3}
    };

    task automatic chk64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chkint(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [31:0] w);
        if (w[30:23] == 8'h00 && w[22:0] != 0) return "R4";
        if (w[30:23] == 8'hFF || w[30:0] == 0) return "R3";
        return "R2";
    endfunction

    // one request; returns edges to done and the result seen with it
    task automatic convert(input logic [31:0] w, output int lat, output logic [63:0] res);
        @(negedge clk_i);
        start_i = 1'b1;
        word_i  = w;
        @(negedge clk_i);
        start_i = 1'b0;
        word_i  = ~w;
        lat = 1;
        while (done_o !== 1'b1 && lat < 40) begin
            @(negedge clk_i);
            lat++;
        end
        res = result_o;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 100000) begin
            nbad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        int lat;
        logic [63:0] res;
        logic [63:0] held;

        // R1 reset state
        repeat (3) @(negedge clk_i);
        chkint("R1 done in reset", int'(done_o), 0);
        chk64("R1 result in reset", result_o, 64'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chkint("R1 done after reset", int'(done_o), 0);
        chk64("R1 result after reset", result_o, 64'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            convert(VEC[i][103:72], lat, res);
            chk64(tag_of(VEC[i][103:72]), res, VEC[i][71:8]);
            chkint("R5 latency", lat, int'(VEC[i][7:0]));
            @(negedge clk_i);
            chkint("R7 single pulse", int'(done_o), 0);
        end

        // R8 result held while idle with changing word
        held = result_o;
        for (int k = 0; k < 8; k++) begin
            word_i = 32'h12345678 * (k + 1);
            @(negedge clk_i);
        end
        chk64("R8 result held", result_o, held);
        chkint("R8 no done", int'(done_o), 0);

        // R6 start during normalization is ignored
        @(negedge clk_i);
        start_i = 1'b1;
        word_i  = 32'h00000001;
        @(negedge clk_i);
        start_i = 1'b0;
        lat = 1;
        @(negedge clk_i); lat++;
        start_i = 1'b1;
        word_i  = 32'h3F800000;
        @(negedge clk_i); lat++;
        chkint("R6 no early done", int'(done_o), 0);
        start_i = 1'b0;
        while (done_o !== 1'b1 && lat < 40) begin
            @(negedge clk_i);
            lat++;
        end
        chkint("R6 latency unchanged", lat, 25);
        chk64("R6 result unchanged", result_o, 64'h36A0000000000000);
        @(negedge clk_i);
        repeat (3) begin
            chkint("R6 no extra done", int'(done_o), 0);
            @(negedge clk_i);
        end

        // R7 back-to-back starts while idle
        start_i = 1'b1;
        word_i  = 32'h40A00000;
        @(negedge clk_i);
        chkint("R7 first done", int'(done_o), 1);
        chk64("R7 first result", result_o, 64'h4014000000000000);
        word_i = 32'hBF800000;
        @(negedge clk_i);
        start_i = 1'b0;
        chkint("R7 second done", int'(done_o), 1);
        chk64("R7 second result", result_o, 64'hBFF0000000000000);
        @(negedge clk_i);
        chkint("R7 done drops", int'(done_o), 0);
        chk64("R8 held after pair", result_o, 64'hBFF0000000000000);

        // R9 reset during normalization
        start_i = 1'b1;
        word_i  = 32'h00000001;
        @(negedge clk_i);
        start_i = 1'b0;
        repeat (5) @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        chkint("R9 done cleared", int'(done_o), 0);
        chk64("R9 result cleared", result_o, 64'd0);
        rst_ni = 1'b1;
        repeat (30) begin
            @(negedge clk_i);
            if (done_o !== 1'b0) begin
                nbad++;
                $display("FAIL R9: got done %b expected 0", done_o);
            end
        end
        nvec++;
        convert(32'h3F800000, lat, res);
        chk64("R9 converts after reset", res, 64'h3FF0000000000000);
        chkint("R9 latency after reset", lat, 1);

        finish_run();
    end
endmodule